// File: doc/BRIEF.md
# Password-to-Key Byte Folding Unit

This block turns a password, presented one byte per cycle with start and last markers, into a 64-bit key. Whitespace bytes at the head of the password are discarded. Each kept byte has its lowercase letters converted to uppercase and is then XORed into one of eight key byte lanes. The lane is the byte's position among the kept bytes, taken modulo eight. The lanes start from zero for each new password.

When the last byte has been accepted, the block presents the folded key, the count of kept bytes and a flag that says whether that count lies inside the allowed length window. It raises a one-cycle valid strobe at the same time. The low bit of every key byte is a parity position that carries no key material, so the block always presents it as zero. The key, length and flag stay unchanged until the next password completes.

Top module: `pwd_key_fold`

## Requirements
- R1: After reset, key_valid, key_out, key_len and len_ok are all zero.
- R2: A byte accepted with in_start high discards any password in progress, clears all lanes and the count, and is itself processed as the first byte of the new password.
- R3: Bytes 0x20, 0x09, 0x0A and 0x0D that precede the first other byte of a password are dropped: they touch no lane and are not counted.
- R4: Once a byte has been kept, later whitespace bytes are folded and counted like any other byte.
- R5: Bytes 0x61 to 0x7A are reduced by 0x20 before folding; every other byte value (including 0x60 and 0x7B) is folded unchanged.
- R6: The kept byte with index i (from 0) is XORed into lane i mod 8, and lane k sits at key_out[8k+7:8k].
- R7: Bit 8k of key_out reads zero for every lane k.
- R8: key_valid is high for exactly one cycle, the cycle after the last byte is accepted; key_out, key_len and len_ok take their new values in that cycle and hold them until the next completed password.
- R9: key_len is the number of kept bytes and saturates at 255.
- R10: len_ok is high exactly when 6 <= key_len <= 40.
- R11: A byte with in_valid high that arrives while no password is open and without in_start is ignored; a stray last marker there gives no key_valid and leaves the outputs unchanged.
- R12: While in_valid is low, in_start, in_last and in_byte have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | in_byte and the markers are valid this cycle |
| in_start | input | 1 | This byte opens a new password |
| in_last | input | 1 | This byte closes the password |
| in_byte | input | 8 | Password byte |
| key_valid | output | 1 | One-cycle strobe: the key is complete |
| key_out | output | 64 | Folded key, lane 0 in the low byte, parity bits zero |
| key_len | output | 8 | Number of kept bytes, saturating |
| len_ok | output | 1 | Kept length is within 6 to 40 |

## Verification
The bench targets the length limits on both sides (5, 6, 40, 41 bytes) and a password made only of whitespace. An off-by-one compare or a counter that includes stripped bytes would flip len_ok there. It mixes leading and inner whitespace, so a design that strips every blank, or none, returns the wrong key. It uses the characters just outside the a to z range, where a loose range compare would corrupt the key. It wraps long passwords past eight bytes, so a wrong lane index breaks the key. It also sends idle gaps carrying junk markers, a stray last marker after completion, a start marker in the middle of a password and a 300-byte password. A design that reacts to these would strobe falsely, change a held key or wrap the length count.

// File: rtl/pkf_pkg.sv
package pkf_pkg;

    localparam logic [7:0] CH_SPACE = 8'h20;
    localparam logic [7:0] CH_TAB   = 8'h09;
    localparam logic [7:0] CH_LF    = 8'h0A;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LO_A  = 8'h61;
    localparam logic [7:0] CH_LO_Z  = 8'h7A;
    localparam logic [7:0] CASE_BIT = 8'h20;

    function automatic logic is_blank(input logic [7:0] b);
        return (b == CH_SPACE) || (b == CH_TAB) || (b == CH_LF) || (b == CH_CR);
    endfunction

endpackage

// File: rtl/pkf_char_norm.sv
module pkf_char_norm
    import pkf_pkg::*;
(
    input  logic [7:0] raw_byte,
    output logic       blank,
    output logic [7:0] norm_byte
);
    logic lower;

    always_comb begin
        blank     = is_blank(raw_byte);
        lower     = (raw_byte >= CH_LO_A) && (raw_byte <= CH_LO_Z);
        norm_byte = lower ? (raw_byte & ~CASE_BIT) : raw_byte;
    end
endmodule

// File: rtl/pkf_lane_xor.sv
module pkf_lane_xor #(
    parameter int LANES = 8,
    localparam int IDX_W = $clog2(LANES),
    localparam int KEY_W = LANES * 8
) (
    input  logic [KEY_W-1:0] lanes_in,
    input  logic [IDX_W-1:0] lane_sel,
    input  logic [7:0]       data,
    input  logic             enable,
    output logic [KEY_W-1:0] lanes_out
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic hit;
        assign hit = enable && (lane_sel == IDX_W'(k));
        assign lanes_out[8*k +: 8] = hit ? (lanes_in[8*k +: 8] ^ data)
                                         : lanes_in[8*k +: 8];
    end
endmodule

// File: rtl/pkf_len_judge.sv
module pkf_len_judge #(
    parameter int LEN_W   = 8,
    parameter int MIN_LEN = 6,
    parameter int MAX_LEN = 40
) (
    input  logic [LEN_W-1:0] len,
    output logic             in_range
);
    localparam logic [LEN_W-1:0] LO = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] HI = LEN_W'(MAX_LEN);

    always_comb begin
        in_range = (len >= LO) && (len <= HI);
    end
endmodule

// File: rtl/pwd_key_fold.sv
module pwd_key_fold #(
    parameter int LANES   = 8,
    parameter int LEN_W   = 8,
    parameter int MIN_LEN = 6,
    parameter int MAX_LEN = 40,
    localparam int IDX_W  = $clog2(LANES),
    localparam int KEY_W  = LANES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_start,
    input  logic             in_last,
    input  logic [7:0]       in_byte,
    output logic             key_valid,
    output logic [KEY_W-1:0] key_out,
    output logic [LEN_W-1:0] key_len,
    output logic             len_ok
);
    localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

    typedef struct packed {
        logic             open;
        logic             strip;
        logic [LEN_W-1:0] cnt;
        logic [KEY_W-1:0] lanes;
        logic             kv;
        logic [KEY_W-1:0] kout;
        logic [LEN_W-1:0] klen;
        logic             kok;
    } state_t;

    state_t st_d, st_q;

    // character path
    logic       blank;
    logic [7:0] norm_byte;

    pkf_char_norm u_norm (
        .raw_byte (in_byte),
        .blank    (blank),
        .norm_byte(norm_byte)
    );

    // per-byte base state (restart on a start marker)
    logic             take;
    logic             keep;
    logic             strip_base;
    logic [LEN_W-1:0] cnt_base;
    logic [LEN_W-1:0] cnt_next;
    logic [KEY_W-1:0] lanes_base;
    logic [KEY_W-1:0] lanes_next;
    logic             next_ok;

    always_comb begin
        take       = in_valid && (in_start || st_q.open);
        strip_base = in_start ? 1'b1 : st_q.strip;
        cnt_base   = in_start ? '0 : st_q.cnt;
        lanes_base = in_start ? '0 : st_q.lanes;
        keep       = take && !(strip_base && blank);
        if (keep && (cnt_base != LEN_MAX)) begin
            cnt_next = cnt_base + LEN_W'(1);
        end else begin
            cnt_next = cnt_base;
        end
    end

    pkf_lane_xor #(
        .LANES(LANES)
    ) u_xor (
        .lanes_in (lanes_base),
        .lane_sel (cnt_base[IDX_W-1:0]),
        .data     (norm_byte),
        .enable   (keep),
        .lanes_out(lanes_next)
    );

    pkf_len_judge #(
        .LEN_W  (LEN_W),
        .MIN_LEN(MIN_LEN),
        .MAX_LEN(MAX_LEN)
    ) u_judge (
        .len     (cnt_next),
        .in_range(next_ok)
    );

    always_comb begin
        st_d    = st_q;
        st_d.kv = 1'b0;
        if (take) begin
            st_d.open  = !in_last;
            st_d.strip = strip_base && !keep;
            st_d.cnt   = cnt_next;
            st_d.lanes = lanes_next;
            if (in_last) begin
                st_d.kv   = 1'b1;
                st_d.kout = lanes_next;
                for (int k = 0; k < LANES; k++) begin
                    st_d.kout[8*k] = 1'b0;
                end
                st_d.klen = cnt_next;
                st_d.kok  = next_ok;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign key_valid = st_q.kv;
    assign key_out   = st_q.kout;
    assign key_len   = st_q.klen;
    assign len_ok    = st_q.kok;
endmodule

// File: rtl/pkf_checker.sv
module pkf_checker #(
    parameter int KEY_W = 64,
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_start,
    input logic             in_last,
    input logic [7:0]       in_byte,
    input logic             key_valid,
    input logic [KEY_W-1:0] key_out,
    input logic [LEN_W-1:0] key_len,
    input logic             len_ok
);
    logic in_blank;
    assign in_blank = (in_byte == 8'h20) || (in_byte == 8'h09) ||
                      (in_byte == 8'h0A) || (in_byte == 8'h0D);

    assert_strobe_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> $past(in_valid && in_last));

    assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_last) |=> (!key_valid && $stable(key_out) &&
                                    $stable(key_len) && $stable(len_ok)));

    assert_blank_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_start && in_last && in_blank) |=>
            (key_valid && key_len == '0 && !len_ok && key_out == '0));

    assert_single_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_start && in_last && !in_blank) |=>
            (key_len == LEN_W'(1) && key_out[KEY_W-1:8] == '0));

    assert_short_invalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> (key_len < LEN_W'(6) ? !len_ok : 1'b1));
endmodule

bind pwd_key_fold pkf_checker #(
    .KEY_W(KEY_W),
    .LEN_W(LEN_W)
) u_pkf_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_start (in_start),
    .in_last  (in_last),
    .in_byte  (in_byte),
    .key_valid(key_valid),
    .key_out  (key_out),
    .key_len  (key_len),
    .len_ok   (len_ok)
);

// File: tb/tb_pwd_key_fold.sv
module tb_pwd_key_fold;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_start, in_last;
    logic [7:0]  in_byte;
    logic        key_valid;
    logic [63:0] key_out;
    logic [7:0]  key_len;
    logic        len_ok;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwd_key_fold dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_last(in_last), .in_byte(in_byte), .key_valid(key_valid),
        .key_out(key_out), .key_len(key_len), .len_ok(len_ok)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference model built from the requirements
    task automatic model(string s, output logic [63:0] k, output int n, output bit ok);
        bit lead = 1'b1;
        k = '0;
        n = 0;
        for (int i = 0; i < s.len(); i++) begin
            logic [7:0] b = s[i];
            bit ws = (b == 8'h20) || (b == 8'h09) || (b == 8'h0A) || (b == 8'h0D);
            if (lead && ws) continue;
            lead = 1'b0;
            if (b >= 8'h61 && b <= 8'h7A) b = b - 8'h20;
            k[8*(n%8) +: 8] = k[8*(n%8) +: 8] ^ b;
            n++;
        end
        for (int j = 0; j < 8; j++) k[8*j] = 1'b0;
        ok = (n >= 6) && (n <= 40);
        if (n > 255) n = 255;
    endtask

    task automatic send(string s, bit gaps);
        for (int i = 0; i < s.len(); i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_start = (i == 0);
            in_last  = (i == s.len() - 1);
            in_byte  = s[i];
            if (gaps && i < s.len() - 1) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_start = 1'b1;
                in_last  = 1'b1;
                in_byte  = 8'h41;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_start = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic run_and_check(string req, string s, bit gaps, bit check_key);
        logic [63:0] k;
        int n;
        bit ok;
        model(s, k, n, ok);
        send(s, gaps);
        chk({req, " strobe"}, 64'(key_valid), 64'd1);
        if (check_key) chk({req, " key"}, key_out, k);
        chk({req, " len"}, 64'(key_len), 64'(n));
        chk({req, " len_ok"}, 64'(len_ok), 64'(ok));
        @(negedge clk);
        chk({req, " strobe one cycle R8"}, 64'(key_valid), 64'd0);
    endtask

    task automatic t_reset();
        chk("R1 key_valid", 64'(key_valid), 64'd0);
        chk("R1 key_out", key_out, 64'd0);
        chk("R1 key_len", 64'(key_len), 64'd0);
        chk("R1 len_ok", 64'(len_ok), 64'd0);
    endtask

    task automatic t_case_fold();
        run_and_check("R5 R6", "secret12", 1'b0, 1'b1);
        run_and_check("R5 edges", "`{az@Z~|", 1'b0, 1'b1);
    endtask

    task automatic t_leading_ws();
        run_and_check("R3", " \t\n\rAbCdEfG", 1'b0, 1'b1);
        run_and_check("R3 blank only", " \t\r\n ", 1'b0, 1'b1);
    endtask

    task automatic t_inner_ws();
        run_and_check("R4", "  ab cd\tef gh", 1'b0, 1'b1);
    endtask

    task automatic t_wrap();
        run_and_check("R6 wrap", "The quick brown fox jumps over 13", 1'b0, 1'b1);
    endtask

    task automatic t_bounds();
        run_and_check("R10 len5", "abcde", 1'b0, 1'b1);
        run_and_check("R10 len6", "abcdef", 1'b0, 1'b1);
        run_and_check("R10 len40", "abcdefghijklmnopqrstuvwxyz0123456789ABCD", 1'b0, 1'b1);
        run_and_check("R10 len41", "abcdefghijklmnopqrstuvwxyz0123456789ABCDE", 1'b0, 1'b1);
    endtask

    task automatic t_parity();
        logic [63:0] pm = 64'h0101010101010101;
        send("qsuwy135", 1'b0);
        chk("R7 parity bits", key_out & pm, 64'd0);
    endtask

    task automatic t_gaps();
        run_and_check("R12", "PassWord99", 1'b1, 1'b1);
    endtask

    task automatic t_stray();
        logic [63:0] k0 = key_out;
        logic [7:0]  l0 = key_len;
        @(negedge clk);
        in_valid = 1'b1; in_start = 1'b0; in_last = 1'b1; in_byte = 8'h7A;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        chk("R11 no strobe", 64'(key_valid), 64'd0);
        chk("R11 key held", key_out, k0);
        chk("R11 len held", 64'(key_len), 64'(l0));
        repeat (3) @(negedge clk);
        chk("R8 hold idle", key_out, k0);
    endtask

    task automatic t_restart();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_start = (i == 0); in_last = 1'b0; in_byte = 8'h51;
        end
        run_and_check("R2 restart", "hello123", 1'b0, 1'b1);
        run_and_check("R2 single", "q", 1'b0, 1'b1);
    endtask

    task automatic t_saturate();
        string s = "";
        for (int i = 0; i < 300; i++) s = {s, "a"};
        run_and_check("R9 saturate", s, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R8 actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0; in_byte = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_case_fold();
        t_leading_ws();
        t_inner_ws();
        t_wrap();
        t_bounds();
        t_parity();
        t_gaps();
        t_stray();
        t_restart();
        t_saturate();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule